// File: doc/BRIEF.md
# Converter Wake-Up Blanking and Overflow Flag

This block sits behind the decimation stage of a stereo 24-bit audio converter. It controls what the data path shows while the converter recovers from power-down. An active-low power-down input clears every piece of internal timing state. Once the input is released, the block counts frame-clock periods. Both channel outputs stay at zero until a fixed initialisation window has elapsed, and that window is one period longer in slave operation than in master operation.

The block also watches both incoming channels for samples close to full scale. When either channel exceeds the limit, it raises a one-frame overflow flag. The flag travels through a delay line so that it appears together with the filtered samples it belongs to. Detection stays disabled for the first frames after wake-up. The delay line is cleared by power-down, so a flag from before a power-down cycle can never appear after it.

Timing runs off the frame clock, sampled in the system clock domain. An edge-select input chooses whether a frame starts on the rising or the falling edge of that clock. The master/slave choice and the high-pass enable are configuration inputs. The block takes them in only while power-down is asserted.

Top module: `adc_wake_ctl`

## Requirements
- R1: While `pd_ni` is low, `left_o`, `right_o` and `ovf_o` read zero in the same cycle. The frame counter and the overflow delay line are cleared, so the next release starts a fresh sequence.
- R2: After release, a frame strobe occurs on each rising edge of `fclk_i` when `fall_sel_i` = 0, and on each falling edge when `fall_sel_i` = 1. The opposite edge has no effect on any output.
- R3: Number the strobes after a release k = 0, 1, 2 and so on. For k < MASTER_LEN when `master_i` = 1, and for k < SLAVE_LEN when `master_i` = 0, both channel outputs are zero. `master_i` is captured only while `pd_ni` is low.
- R4: For strobes past the blanking window, each channel output takes the input sample seen at that strobe in the following cycle, and holds it until the next strobe.
- R5: A sample counts as overflowing when, read as WIDTH-bit two's complement, it is above OVF_LIMIT or below −OVF_LIMIT. With the defaults, this includes the most negative code 0x800000. An overflow on either channel raises the flag.
- R6: Overflow detection is disabled for strobes k < MASK_LEN.
- R7: After strobe j, `ovf_o` equals the detection result from strobe j − OVF_DELAY. The flag lasts exactly one frame per detection and is zero for j < OVF_DELAY.
- R8: `hpf_en_o` follows `hpf_req_i` while `pd_ni` is low. It keeps its value while `pd_ni` is high.
- R9: A detection that is still in flight when power-down is asserted never appears on `ovf_o` after the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Power-down, active low, synchronous |
| fclk_i | input | 1 | Frame clock level, sampled by clk_i |
| fall_sel_i | input | 1 | 1: frames start on the falling edge of fclk_i |
| master_i | input | 1 | 1: master blanking length, 0: slave |
| hpf_req_i | input | 1 | Requested high-pass enable |
| left_i | input | WIDTH | Left sample from the filter |
| right_i | input | WIDTH | Right sample from the filter |
| left_o | output | WIDTH | Gated left sample |
| right_o | output | WIDTH | Gated right sample |
| ovf_o | output | 1 | Delayed overflow flag |
| hpf_en_o | output | 1 | High-pass enable in effect |

## Verification
The bench builds the block with MASTER_LEN 5, SLAVE_LEN 6, MASK_LEN 4 and OVF_DELAY 3, and keeps the 24-bit width and the default limit. With these values every run crosses the blanking edge in both modes, the mask edge and the delay alignment within a few dozen frames. This leaves room for repeated power-down cycles in both edge modes. Exact threshold codes on either side of the limit, including the most negative code, are mixed into random samples.

// File: rtl/adc_wake_pkg.sv
package adc_wake_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef struct packed {
    logic slave;
    logic hpf;
  } wake_cfg_t;
endpackage

// File: rtl/adc_frame_edge.sv
module adc_frame_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fclk_i,
  input  logic fall_sel_i,
  input  logic en_i,
  output logic stb_o
);
  logic fclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fclk_q <= 1'b0;
    else         fclk_q <= fclk_i;
  end

  assign stb_o = en_i & (fall_sel_i ? (fclk_q & ~fclk_i) : (fclk_i & ~fclk_q));
endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq #(
  parameter int unsigned MASTER_LEN = 516,
  parameter int unsigned SLAVE_LEN  = 517,
  parameter int unsigned MASK_LEN   = 516,
  parameter int unsigned SAT        = 518,
  parameter int unsigned CNT_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic             slave_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] blank_len_o,
  output logic             data_en_o,
  output logic             det_en_o
);
  localparam logic [CNT_W-1:0] SAT_C    = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] MASTER_C = CNT_W'(MASTER_LEN);
  localparam logic [CNT_W-1:0] SLAVE_C  = CNT_W'(SLAVE_LEN);
  localparam logic [CNT_W-1:0] MASK_C   = CNT_W'(MASK_LEN);

  // saturates one past the longest window so every compare stays valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (stb_i && cnt_o != SAT_C) cnt_o <= cnt_o + 1'b1;
  end

  assign blank_len_o = slave_i ? SLAVE_C : MASTER_C;
  assign data_en_o   = cnt_o >= blank_len_o;
  assign det_en_o    = cnt_o >= MASK_C;
endmodule

// File: rtl/adc_ovf_pipe.sv
module adc_ovf_pipe #(
  parameter int unsigned DELAY = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  input  logic det_i,
  output logic ovf_o
);
  logic [DELAY:0] stg;

  for (genvar i = 0; i <= DELAY; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stg[0] <= 1'b0;
        else if (clr_i) stg[0] <= 1'b0;
        else if (stb_i) stg[0] <= det_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stg[i] <= 1'b0;
        else if (clr_i) stg[i] <= 1'b0;
        else if (stb_i) stg[i] <= stg[i-1];
      end
    end
  end

  assign ovf_o = stg[DELAY];
endmodule

// File: rtl/adc_wake_ctl.sv
module adc_wake_ctl #(
  parameter int unsigned WIDTH      = 24,
  parameter int unsigned MASTER_LEN = 516,
  parameter int unsigned SLAVE_LEN  = 517,
  parameter int unsigned MASK_LEN   = 516,
  parameter int unsigned OVF_DELAY  = 13,
  parameter int unsigned OVF_LIMIT  = 8103800
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             fclk_i,
  input  logic             fall_sel_i,
  input  logic             master_i,
  input  logic             hpf_req_i,
  input  logic [WIDTH-1:0] left_i,
  input  logic [WIDTH-1:0] right_i,
  output logic [WIDTH-1:0] left_o,
  output logic [WIDTH-1:0] right_o,
  output logic             ovf_o,
  output logic             hpf_en_o
);
  import adc_wake_pkg::*;

  localparam int unsigned LONG_MS = (MASTER_LEN > SLAVE_LEN) ? MASTER_LEN : SLAVE_LEN;
  localparam int unsigned LONGEST = (LONG_MS > MASK_LEN) ? LONG_MS : MASK_LEN;
  localparam int unsigned SAT     = LONGEST + 1;
  localparam int unsigned CNT_W   = $clog2(SAT + 1);
  localparam logic signed [WIDTH-1:0] LIM_P = WIDTH'(OVF_LIMIT);
  localparam logic signed [WIDTH-1:0] LIM_N = -LIM_P;

  wake_cfg_t        cfg_q;
  logic             frame_stb;
  logic [CNT_W-1:0] init_cnt;
  logic [CNT_W-1:0] blank_len;
  logic             data_en;
  logic             det_en;
  logic             ovf_raw;
  logic [NUM_CH-1:0] ch_over;
  logic [WIDTH-1:0] samp [NUM_CH];
  logic [WIDTH-1:0] samp_q [NUM_CH];

  // configuration taken in only during power-down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (!pd_ni) cfg_q <= '{slave: ~master_i, hpf: hpf_req_i};
  end

  adc_frame_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fclk_i     (fclk_i),
    .fall_sel_i (fall_sel_i),
    .en_i       (pd_ni),
    .stb_o      (frame_stb)
  );

  adc_init_seq #(
    .MASTER_LEN (MASTER_LEN),
    .SLAVE_LEN  (SLAVE_LEN),
    .MASK_LEN   (MASK_LEN),
    .SAT        (SAT),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (~pd_ni),
    .stb_i       (frame_stb),
    .slave_i     (cfg_q.slave),
    .cnt_o       (init_cnt),
    .blank_len_o (blank_len),
    .data_en_o   (data_en),
    .det_en_o    (det_en)
  );

  assign samp[0] = left_i;
  assign samp[1] = right_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_over[c] = ($signed(samp[c]) > LIM_P) || ($signed(samp[c]) < LIM_N);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        samp_q[c] <= '0;
      else if (!pd_ni)    samp_q[c] <= '0;
      else if (frame_stb) samp_q[c] <= data_en ? samp[c] : '0;
    end
  end

  adc_ovf_pipe #(.DELAY(OVF_DELAY)) u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~pd_ni),
    .stb_i  (frame_stb),
    .det_i  (det_en & (|ch_over)),
    .ovf_o  (ovf_raw)
  );

  // gate so outputs drop in the cycle power-down is asserted
  assign left_o   = pd_ni ? samp_q[0] : '0;
  assign right_o  = pd_ni ? samp_q[1] : '0;
  assign ovf_o    = pd_ni & ovf_raw;
  assign hpf_en_o = cfg_q.hpf;
endmodule

// File: rtl/adc_wake_ctl_chk.sv
module adc_wake_ctl_chk #(
  parameter int unsigned WIDTH    = 24,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MASK_LEN = 516
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_ni,
  input logic             stb,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] blank_len,
  input logic [WIDTH-1:0] left_o,
  input logic [WIDTH-1:0] right_o,
  input logic             ovf_o,
  input logic             hpf_en_o
);
  localparam logic [CNT_W-1:0] MASK_C = CNT_W'(MASK_LEN);

  assert_pd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |-> (left_o == '0 && right_o == '0 && !ovf_o));

  assert_blank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ni && cnt <= blank_len) |-> (left_o == '0 && right_o == '0));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ni && $past(pd_ni) && !$past(stb)) |-> ($stable(left_o) && $stable(right_o)));

  assert_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt <= MASK_C) |-> !ovf_o);

  assert_ovf_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ni && $past(pd_ni) && !$past(stb)) |-> $stable(ovf_o));

  assert_hpf_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pd_ni) |-> $stable(hpf_en_o));
endmodule

bind adc_wake_ctl adc_wake_ctl_chk #(
  .WIDTH    (WIDTH),
  .CNT_W    (CNT_W),
  .MASK_LEN (MASK_LEN)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pd_ni     (pd_ni),
  .stb       (frame_stb),
  .cnt       (init_cnt),
  .blank_len (blank_len),
  .left_o    (left_o),
  .right_o   (right_o),
  .ovf_o     (ovf_o),
  .hpf_en_o  (hpf_en_o)
);

// File: tb/adc_wake_ctl_tb_top.sv
module adc_wake_ctl_tb_top;
  localparam int W     = 24;
  localparam int M_LEN = 5;
  localparam int S_LEN = 6;
  localparam int MSK   = 4;
  localparam int DLY   = 3;
  localparam int LIM   = 8103800;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pd_ni = 1'b0;
  logic fclk = 1'b0;
  logic fall_sel = 1'b0;
  logic master = 1'b1;
  logic hpf_req = 1'b0;
  logic [W-1:0] left_i = '0;
  logic [W-1:0] right_i = '0;
  logic [W-1:0] left_o, right_o;
  logic ovf_o, hpf_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int k;
  bit cur_master, cur_fall, cur_hpf;
  bit hist [0:255];

  always #4 clk = ~clk;

  adc_wake_ctl #(
    .WIDTH(W), .MASTER_LEN(M_LEN), .SLAVE_LEN(S_LEN),
    .MASK_LEN(MSK), .OVF_DELAY(DLY), .OVF_LIMIT(LIM)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni), .fclk_i(fclk),
    .fall_sel_i(fall_sel), .master_i(master), .hpf_req_i(hpf_req),
    .left_i(left_i), .right_i(right_i), .left_o(left_o),
    .right_o(right_o), .ovf_o(ovf_o), .hpf_en_o(hpf_en_o)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_over(logic [W-1:0] x);
    int v = int'($signed(x));
    return (v > LIM) || (v < -LIM);
  endfunction

  function automatic logic [W-1:0] corner(int n);
    case (n % 6)
      0: return W'(LIM);
      1: return W'(LIM + 1);
      2: return W'(-LIM);
      3: return W'(-LIM - 1);
      4: return 24'h800000;
      default: return 24'h7fffff;
    endcase
  endfunction

  task automatic start_run(bit mst, bit fall, bit hpf);
    @(negedge clk);
    pd_ni = 1'b0;
    #1;
    chk("R1", "left in pd", left_o, 0);
    chk("R1", "ovf in pd", ovf_o, 0);
    master = mst; fall_sel = fall; hpf_req = hpf;
    fclk = fall;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "hpf taken in pd", hpf_en_o, hpf);
    chk("R1", "right in pd", right_o, 0);
    cur_master = mst; cur_fall = fall; cur_hpf = hpf;
    pd_ni = 1'b1;
    k = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic frame(logic [W-1:0] l, logic [W-1:0] r);
    int blank;
    logic [W-1:0] el, er;
    bit eo;
    string oreq;
    @(negedge clk);
    left_i = l; right_i = r;
    fclk = ~cur_fall;
    repeat (3) @(posedge clk);
    @(negedge clk);
    blank = cur_master ? M_LEN : S_LEN;
    el = (k < blank) ? '0 : l;
    er = (k < blank) ? '0 : r;
    hist[k] = (k >= MSK) && (is_over(l) || is_over(r));
    eo = (k >= DLY) ? hist[k-DLY] : 1'b0;
    if (k < DLY) oreq = "R9";
    else if (k - DLY < MSK) oreq = "R6";
    else oreq = "R5/R7";
    chk((k < blank) ? "R3" : "R4", "left", left_o, el);
    chk((k < blank) ? "R3" : "R4", "right", right_o, er);
    chk(oreq, "ovf", ovf_o, eo);
    k++;
    fclk = cur_fall;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2", "left after other edge", left_o, el);
    chk("R2", "ovf after other edge", ovf_o, eo);
  endtask

  task automatic run_frames(int n, bit force_tail);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] l = W'($urandom);
      logic [W-1:0] r = W'($urandom);
      if (i % 4 == 1) begin
        if (i % 8 == 1) l = corner(i / 4);
        else r = corner(i / 4);
      end
      if (force_tail && i >= n - 2) l = 24'h800000;
      frame(l, r);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset left", left_o, 0);
    chk("R1", "reset ovf", ovf_o, 0);
    chk("R8", "reset hpf", hpf_en_o, 0);
    rst_ni = 1'b1;

    start_run(1'b1, 1'b0, 1'b1);
    run_frames(14, 1'b1);
    @(negedge clk);
    hpf_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "hpf ignored in run", hpf_en_o, 1);

    start_run(1'b0, 1'b1, 1'b0);
    run_frames(24, 1'b1);

    start_run(1'b1, 1'b1, 1'b1);
    frame(24'h800000, 24'h0);
    frame(24'h0, W'(LIM + 1));
    run_frames(12, 1'b0);

    start_run(1'b0, 1'b0, 1'b0);
    run_frames(30, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule